// File: doc/BRIEF.md
# HDLC Receive FIFO and Overrun Handler

This block sits on the receive path between the HDLC deserializer and the buffer writer. It holds a small receive FIFO of three bytes and tells the buffer writer and the CRC unit when a frame's first byte has been stored. It also detects the condition in which the FIFO cannot take an arriving byte. When that happens, the byte that arrived replaces the newest stored byte. The block then stops accepting input and reports the frame through a descriptor close carrying the overrun flag. When the report is done, it sends the receiver back to flag hunting.

The deserializer delivers bytes with a valid strobe. It also pulses an opening-flag indication and a closing-flag indication. The address-recognition logic supplies a match level for the current frame. The buffer writer takes the FIFO head each cycle in which it raises the drain input. A descriptor is closed only after the FIFO has fully drained. If the frame's address did not match and the frame ended normally, no descriptor is written. If an overrun occurs in such a frame, a descriptor of fixed length two is still written so that the error is reported.

Top module: `hdlc_rx_ovr`

## Requirements
- R1: After reset, `hunt` is 1 and `fifo_valid`, `buf_start`, `desc_close`, `irq_rxf` and `irq_rxb` are 0.
- R2: While in hunt mode, received bytes are discarded and `fifo_valid` stays 0 until `frame_start` is pulsed.
- R3: During a frame, up to 3 stored bytes are presented on `fifo_data` in arrival order. `fifo_valid` is high whenever the FIFO holds at least one byte. Each cycle with `drain` high while `fifo_valid` is high removes the head byte.
- R4: `buf_start` pulses for one cycle exactly once per frame, on the cycle after the frame's first byte is stored.
- R5: An overrun happens when a byte arrives while 3 bytes are stored and `drain` is low. A byte that arrives with 3 bytes stored and `drain` high is stored normally and is not an overrun.
- R6: On an overrun, the arriving byte replaces the most recently stored byte. No byte is stored after that until the next `frame_start`, and `frame_end` is ignored.
- R7: After an overrun in a matched frame (`addr_match`=1), once the FIFO is empty, `desc_close` pulses with `desc_ov`=1 and `desc_len` equal to the number of bytes that took a new FIFO entry. `irq_rxf` pulses with it when `rxf_en` is 1.
- R8: After an overrun in an unmatched frame (`addr_match`=0), once the FIFO is empty, `desc_close` pulses with `desc_ov`=1 and `desc_len`=2. `irq_rxb` pulses with it when `rxb_en` is 1.
- R9: After `frame_end` with no overrun, a matched frame closes with `desc_ov`=0, `desc_len` equal to its stored byte count and `irq_rxf` when enabled. An unmatched frame produces no `desc_close` and no interrupt.
- R10: In the cycle `desc_close` is high, `hunt` is 1 and `fifo_valid` is 0.
- R11: `irq_rxf` and `irq_rxb` are single-cycle pulses. Each occurs only together with `desc_close` and only when its own enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte from the deserializer |
| rx_valid | input | 1 | `rx_data` holds a new byte this cycle |
| frame_start | input | 1 | Opening flag seen; leaves hunt mode |
| frame_end | input | 1 | Closing flag seen |
| addr_match | input | 1 | Address of the current frame matched |
| drain | input | 1 | Buffer writer takes the FIFO head this cycle |
| rxf_en | input | 1 | Enable for the frame interrupt |
| rxb_en | input | 1 | Enable for the buffer interrupt |
| fifo_data | output | 8 | FIFO head byte |
| fifo_valid | output | 1 | FIFO holds at least one byte |
| buf_start | output | 1 | Pulse: first byte of the frame stored; start buffer and CRC |
| desc_close | output | 1 | Pulse: close the descriptor |
| desc_len | output | 16 | Length reported with the close |
| desc_ov | output | 1 | Overrun status reported with the close |
| irq_rxf | output | 1 | Frame interrupt pulse |
| irq_rxb | output | 1 | Buffer interrupt pulse |
| hunt | output | 1 | Receiver is in flag-hunt mode |

## Verification
The FIFO head is combinational from the stored state. It is compared in the same cycle that `drain` is high, before the edge that removes the byte. `buf_start` arrives one edge after the first store. `desc_close`, `desc_len`, `desc_ov` and the interrupts arrive one edge after the cycle in which the FIFO is seen empty in the closing state. The bench therefore drives inputs just after a rising edge and samples every output on the falling edge. A driver queues the expected bytes and descriptors. A monitor pops and compares them whenever a drain or a close is visible. The bench also counts `buf_start` pulses and closes per frame, which catches missing or extra events.

// File: rtl/hrx_pkg.sv
package hrx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_FRAME = 2'd1,
        ST_CLOSE = 2'd2
    } hrx_state_e;
endpackage

// File: rtl/hrx_fifo.sv
module hrx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 3,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          ovw,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } fifo_s;

    fifo_s q, d;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    logic [PW-1:0] last_idx;
    assign last_idx = (q.wr == '0) ? PW'(DEPTH - 1) : q.wr - PW'(1);

    always_comb begin
        d = q;
        if (clr) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end else begin
            if (ovw) begin
                d.mem[last_idx] = wdata;
            end else if (push) begin
                d.mem[q.wr] = wdata;
                d.wr        = step_ptr(q.wr);
            end
            if (pop) begin
                d.rd = step_ptr(q.rd);
            end
            if (push && !ovw && !pop) begin
                d.cnt = q.cnt + CW'(1);
            end else if (pop && !(push && !ovw)) begin
                d.cnt = q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.mem[q.rd];
    assign count = q.cnt;
endmodule

// File: rtl/hrx_ctrl.sv
module hrx_ctrl
    import hrx_pkg::*;
#(
    parameter int DEPTH   = 3,
    parameter int LEN_W   = 16,
    parameter int OVR_LEN = 2,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             rx_valid,
    input  logic             addr_match,
    input  logic             drain,
    input  logic [CW-1:0]    fifo_cnt,
    input  logic             rxf_en,
    input  logic             rxb_en,
    output logic             push,
    output logic             ovw,
    output logic             pop,
    output logic             clr,
    output logic             buf_start,
    output logic             desc_close,
    output logic [LEN_W-1:0] desc_len,
    output logic             desc_ov,
    output logic             irq_rxf,
    output logic             irq_rxb,
    output logic             hunt,
    output logic             in_frame
);
    typedef struct packed {
        hrx_state_e       st;
        logic [LEN_W-1:0] len;
        logic             ov;
        logic             matched;
        logic             bstart;
        logic             close;
        logic [LEN_W-1:0] dlen;
        logic             dov;
        logic             rxf;
        logic             rxb;
    } ctrl_s;

    ctrl_s q, d;
    logic  full;

    assign full = (fifo_cnt == CW'(DEPTH));

    always_comb begin
        d        = q;
        d.bstart = 1'b0;
        d.close  = 1'b0;
        d.rxf    = 1'b0;
        d.rxb    = 1'b0;
        push     = 1'b0;
        ovw      = 1'b0;
        clr      = 1'b0;
        pop      = drain && (fifo_cnt != '0);
        unique case (q.st)
            ST_HUNT: begin
                clr = 1'b1;
                pop = 1'b0;
                if (frame_start) begin
                    d.st  = ST_FRAME;
                    d.len = '0;
                    d.ov  = 1'b0;
                end
            end
            ST_FRAME: begin
                if (rx_valid && full && !pop) begin
                    ovw       = 1'b1;
                    d.ov      = 1'b1;
                    d.matched = addr_match;
                    d.st      = ST_CLOSE;
                end else begin
                    if (rx_valid) begin
                        push     = 1'b1;
                        d.len    = q.len + LEN_W'(1);
                        d.bstart = (q.len == '0);
                    end
                    if (frame_end) begin
                        d.matched = addr_match;
                        d.st      = ST_CLOSE;
                    end
                end
            end
            ST_CLOSE: begin
                if (fifo_cnt == '0) begin
                    d.st = ST_HUNT;
                    if (q.ov) begin
                        d.close = 1'b1;
                        d.dov   = 1'b1;
                        if (q.matched) begin
                            d.dlen = q.len;
                            d.rxf  = rxf_en;
                        end else begin
                            d.dlen = LEN_W'(OVR_LEN);
                            d.rxb  = rxb_en;
                        end
                    end else if (q.matched) begin
                        d.close = 1'b1;
                        d.dov   = 1'b0;
                        d.dlen  = q.len;
                        d.rxf   = rxf_en;
                    end
                end
            end
            default: d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_HUNT;
        end else begin
            q <= d;
        end
    end

    assign buf_start  = q.bstart;
    assign desc_close = q.close;
    assign desc_len   = q.dlen;
    assign desc_ov    = q.dov;
    assign irq_rxf    = q.rxf;
    assign irq_rxb    = q.rxb;
    assign hunt       = (q.st == ST_HUNT);
    assign in_frame   = (q.st == ST_FRAME);
endmodule

// File: rtl/hdlc_rx_ovr.sv
module hdlc_rx_ovr #(
    parameter int DW      = 8,
    parameter int DEPTH   = 3,
    parameter int LEN_W   = 16,
    parameter int OVR_LEN = 2,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    rx_data,
    input  logic             rx_valid,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             addr_match,
    input  logic             drain,
    input  logic             rxf_en,
    input  logic             rxb_en,
    output logic [DW-1:0]    fifo_data,
    output logic             fifo_valid,
    output logic             buf_start,
    output logic             desc_close,
    output logic [LEN_W-1:0] desc_len,
    output logic             desc_ov,
    output logic             irq_rxf,
    output logic             irq_rxb,
    output logic             hunt
);
    logic          push, ovw, pop, clr, in_frame;
    logic [CW-1:0] fifo_cnt;

    hrx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (push),
        .ovw   (ovw),
        .pop   (pop),
        .wdata (rx_data),
        .rdata (fifo_data),
        .count (fifo_cnt)
    );

    hrx_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .OVR_LEN(OVR_LEN)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .rx_valid    (rx_valid),
        .addr_match  (addr_match),
        .drain       (drain),
        .fifo_cnt    (fifo_cnt),
        .rxf_en      (rxf_en),
        .rxb_en      (rxb_en),
        .push        (push),
        .ovw         (ovw),
        .pop         (pop),
        .clr         (clr),
        .buf_start   (buf_start),
        .desc_close  (desc_close),
        .desc_len    (desc_len),
        .desc_ov     (desc_ov),
        .irq_rxf     (irq_rxf),
        .irq_rxb     (irq_rxb),
        .hunt        (hunt),
        .in_frame    (in_frame)
    );

    assign fifo_valid = (fifo_cnt != '0);
endmodule

// File: rtl/hrx_checker.sv
module hrx_checker #(
    parameter int DEPTH   = 3,
    parameter int LEN_W   = 16,
    parameter int OVR_LEN = 2,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             drain,
    input logic [CW-1:0]    fifo_cnt,
    input logic             in_frame,
    input logic             hunt,
    input logic             fifo_valid,
    input logic             desc_close,
    input logic [LEN_W-1:0] desc_len,
    input logic             desc_ov,
    input logic             irq_rxf,
    input logic             irq_rxb
);
    p_hunt_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hunt |-> !fifo_valid);

    p_full_drain_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && fifo_cnt == CW'(DEPTH) && rx_valid && drain)
        |=> (fifo_cnt == CW'(DEPTH) && !hunt));

    p_overrun_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && fifo_cnt == CW'(DEPTH) && rx_valid && !drain)
        |=> (!in_frame && !hunt && fifo_cnt == CW'(DEPTH)));

    p_rxb_fixed_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rxb |-> (desc_ov && desc_len == LEN_W'(OVR_LEN)));

    p_close_in_hunt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        desc_close |-> (hunt && !fifo_valid));

    p_close_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        desc_close |=> !desc_close);

    p_irq_with_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rxf || irq_rxb) |-> desc_close);

    p_irq_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_rxf && irq_rxb));
endmodule

bind hdlc_rx_ovr hrx_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W), .OVR_LEN(OVR_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .drain      (drain),
    .fifo_cnt   (fifo_cnt),
    .in_frame   (in_frame),
    .hunt       (hunt),
    .fifo_valid (fifo_valid),
    .desc_close (desc_close),
    .desc_len   (desc_len),
    .desc_ov    (desc_ov),
    .irq_rxf    (irq_rxf),
    .irq_rxb    (irq_rxb)
);

// File: tb/tb_hdlc_rx_ovr.sv
module tb_hdlc_rx_ovr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
    logic        addr_match = 1'b0, drain = 1'b0, rxf_en = 1'b0, rxb_en = 1'b0;
    logic [7:0]  fifo_data;
    logic        fifo_valid, buf_start, desc_close, desc_ov, irq_rxf, irq_rxb, hunt;
    logic [15:0] desc_len;

    hdlc_rx_ovr dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .frame_start(frame_start), .frame_end(frame_end), .addr_match(addr_match),
        .drain(drain), .rxf_en(rxf_en), .rxb_en(rxb_en), .fifo_data(fifo_data),
        .fifo_valid(fifo_valid), .buf_start(buf_start), .desc_close(desc_close),
        .desc_len(desc_len), .desc_ov(desc_ov), .irq_rxf(irq_rxf),
        .irq_rxb(irq_rxb), .hunt(hunt)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    len;
        bit    ov;
        bit    rxf;
        bit    rxb;
        string req;
    } desc_t;

    int          checks = 0;
    int          fails = 0;
    int          cycles = 0;
    int          buf_seen = 0;
    int          desc_seen = 0;
    bit          done = 1'b0;
    logic [7:0]  exp_b[$];
    desc_t       exp_d[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            chk(1'b0, "WATCHDOG", "run did not complete", cycles, 20000);
            summary();
        end
    end

    // Monitor: scoreboard for FIFO bytes (R3, R6) and descriptors (R7..R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_valid && drain) begin
                if (exp_b.size() == 0) begin
                    chk(1'b0, "R3", "unexpected drained byte", fifo_data, -1);
                end else begin
                    logic [7:0] e;
                    e = exp_b.pop_front();
                    chk(fifo_data == e, "R3/R6", "drained byte", fifo_data, e);
                end
            end
            if (buf_start) buf_seen++;
            if (desc_close) begin
                desc_seen++;
                if (exp_d.size() == 0) begin
                    chk(1'b0, "R9", "unexpected desc_close", 1, 0);
                end else begin
                    desc_t e;
                    e = exp_d.pop_front();
                    chk(desc_len == 16'(e.len), e.req, "desc_len", desc_len, e.len);
                    chk(desc_ov == e.ov, e.req, "desc_ov", desc_ov, e.ov);
                    chk(irq_rxf == e.rxf, "R11", "irq_rxf", irq_rxf, e.rxf);
                    chk(irq_rxb == e.rxb, "R11", "irq_rxb", irq_rxb, e.rxb);
                end
                chk(hunt && !fifo_valid, "R10", "hunt/empty at close", {hunt, fifo_valid}, 2);
            end else begin
                chk(!irq_rxf && !irq_rxb, "R11", "irq without close", {irq_rxf, irq_rxb}, 0);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit stored);
        rx_data = b;
        rx_valid = 1'b1;
        step();
        rx_valid = 1'b0;
        if (stored) exp_b.push_back(b);
    endtask

    task automatic open_frame(input bit match);
        addr_match = match;
        frame_start = 1'b1;
        step();
        frame_start = 1'b0;
    endtask

    task automatic close_frame();
        frame_end = 1'b1;
        step();
        frame_end = 1'b0;
    endtask

    task automatic wait_hunt();
        drain = 1'b1;
        while (!hunt) step();
        step();
        drain = 1'b0;
        step();
    endtask

    initial begin
        int b0, d0;
        repeat (3) step();
        // R1: reset state
        chk(hunt == 1'b1, "R1", "hunt after reset", hunt, 1);
        chk(!fifo_valid && !buf_start && !desc_close && !irq_rxf && !irq_rxb,
            "R1", "outputs idle after reset",
            {fifo_valid, buf_start, desc_close, irq_rxf, irq_rxb}, 0);
        rst_n = 1'b1;
        step();

        // R2: bytes in hunt mode are discarded
        b0 = buf_seen;
        for (int i = 0; i < 3; i++) begin
            send_byte(8'h10 + 8'(i), 1'b0);
            chk(!fifo_valid, "R2", "fifo_valid in hunt", fifo_valid, 0);
        end
        chk(buf_seen == b0, "R2", "buf_start in hunt", buf_seen - b0, 0);

        // R9/R3/R4: matched frame, continuous drain, no overrun
        rxf_en = 1'b1; rxb_en = 1'b1;
        b0 = buf_seen;
        open_frame(1'b1);
        drain = 1'b1;
        for (int i = 0; i < 5; i++) send_byte(8'h20 + 8'(i), 1'b1);
        exp_d.push_back('{len: 5, ov: 1'b0, rxf: 1'b1, rxb: 1'b0, req: "R9"});
        close_frame();
        wait_hunt();
        chk(buf_seen == b0 + 1, "R4", "buf_start pulses per frame", buf_seen - b0, 1);

        // R5/R6/R7: matched overrun, extra bytes ignored
        b0 = buf_seen;
        open_frame(1'b1);
        send_byte(8'h31, 1'b1);
        send_byte(8'h32, 1'b1);
        send_byte(8'h33, 1'b1);
        chk(!hunt, "R5", "not overrun at three stored", hunt, 0);
        send_byte(8'h34, 1'b0);
        exp_b[exp_b.size() - 1] = 8'h34;
        send_byte(8'h35, 1'b0);
        send_byte(8'h36, 1'b0);
        close_frame();
        exp_d.push_back('{len: 3, ov: 1'b1, rxf: 1'b1, rxb: 1'b0, req: "R7"});
        wait_hunt();
        chk(buf_seen == b0 + 1, "R4", "buf_start once in overrun frame", buf_seen - b0, 1);

        // R8: unmatched overrun reports length two with buffer interrupt
        open_frame(1'b0);
        for (int i = 0; i < 3; i++) send_byte(8'h40 + 8'(i), 1'b1);
        send_byte(8'h4F, 1'b0);
        exp_b[exp_b.size() - 1] = 8'h4F;
        exp_d.push_back('{len: 2, ov: 1'b1, rxf: 1'b0, rxb: 1'b1, req: "R8"});
        wait_hunt();

        // R9: unmatched frame ending normally gives no descriptor
        d0 = desc_seen;
        open_frame(1'b0);
        drain = 1'b1;
        send_byte(8'h51, 1'b1);
        send_byte(8'h52, 1'b1);
        close_frame();
        wait_hunt();
        chk(desc_seen == d0, "R9", "no close for unmatched frame", desc_seen - d0, 0);

        // R5: store and drain on a full FIFO in the same cycle is not an overrun
        open_frame(1'b1);
        for (int i = 0; i < 3; i++) send_byte(8'h60 + 8'(i), 1'b1);
        drain = 1'b1;
        send_byte(8'h63, 1'b1);
        chk(!hunt, "R5", "still receiving after full store+drain", hunt, 0);
        exp_d.push_back('{len: 4, ov: 1'b0, rxf: 1'b1, rxb: 1'b0, req: "R5"});
        close_frame();
        wait_hunt();

        // R11: disabled interrupts on a matched overrun
        rxf_en = 1'b0; rxb_en = 1'b0;
        open_frame(1'b1);
        for (int i = 0; i < 4; i++) send_byte(8'h70 + 8'(i), i < 3);
        exp_b[exp_b.size() - 1] = 8'h73;
        exp_d.push_back('{len: 3, ov: 1'b1, rxf: 1'b0, rxb: 1'b0, req: "R11"});
        wait_hunt();

        repeat (3) step();
        chk(exp_b.size() == 0, "R3", "bytes left undrained", exp_b.size(), 0);
        chk(exp_d.size() == 0, "R7", "descriptors missing", exp_d.size(), 0);
        done = 1'b1;
        summary();
    end
endmodule